// File: doc/BRIEF.md
# Transmit Overhead Source Selector

This block sits in the transmit path of a DS3/E3 framer and picks, one bit at a time, where each transmitted bit comes from. A frame timing counter outside the block tags every bit position with an overhead class code. For each position the block chooses one of these sources:

- the internally generated overhead bit;
- an external serial insertion input;
- the payload data stream;
- a programmable payload-dependent value;
- a forced zero;
- the internal multiframe indicator.

The choice depends on the framing mode and on a small control register. A forced-alarm input overrides every other choice.

When the block selects the external input, it raises a request strobe in the same cycle, so the source can present its bit in that cycle. The block also keeps a 2-bit multiframe indicator counter, which is advanced by a frame-start pulse. In G.832 the indicator can be carried in two bits of the MA byte. Frame counting, parity calculation and line coding are done elsewhere.

Top module: `tx_oh_select`

## Requirements
- R1: After reset the control register reads 00h and the multiframe indicator reads 00. A write stores bits 6..0, and bit 7 always reads 0. Control bit positions: 0 ext X/A/RDI, 1 ext parity, 2 ext frame alignment, 3 ext stuff, 4 ext data, 5 ext FEAC/payload-dependent, 6 ext CP/trail-trace.
- R2: While `alm_force` is 1, `tx_bit` equals `alm_bit` and `ext_req` is 0, in every mode and for every class, including when ext data is set.
- R3: With no alarm and ext data set, every overhead class (codes 1..15) sends `pay_bit`, with `ext_req` 0, in all modes.
- R4: Class 0 (payload) always sends `pay_bit`, with `ext_req` 0, when no alarm is forced.
- R5: Class 1 (frame alignment) sends `ext_bit` when ext frame alignment is set and `int_bit` otherwise, in all modes.
- R6: Class 2 (parity) sends `ext_bit` when ext parity is set and the mode is DS3 (mode 0 C-bit or mode 1 M13). Otherwise it sends `int_bit`. Modes 2 (G.751) and 3 (G.832) ignore the control bit.
- R7: Class 3 (stuff opportunity) sends `ext_bit` when ext stuff is set in mode 1 or mode 2. Otherwise it sends `pay_bit`.
- R8: Class 5 (CP/trail trace) sends `ext_bit` when ext CP/TR is set in mode 0 or mode 3. With the bit clear it sends `int_bit` in mode 0 and 0 in mode 3. In modes 1 and 2 it always sends `int_bit`.
- R9: Class 6 (FEAC/payload-dependent) sends `ext_bit` when ext FEAC/PD is set in mode 0 or mode 3. With the bit clear it sends `int_bit` in mode 0 and `pd_bit` in mode 3. In modes 1 and 2 it always sends `int_bit`.
- R10: Classes 7 and 8 (MA indicator high/low bits) behave as follows. In mode 3 with ext FEAC/PD set they send `ext_bit`. With that bit clear they send `mfi_q[1]` (class 7) or `mfi_q[0]` (class 8) when `mfi_en` is 1, and `pd_bit` when `mfi_en` is 0. In modes 0..2 they send `int_bit`.
- R11: Class 4 (X/A/RDI) sends `ext_bit` when ext X/A/RDI is set, but in modes 2 and 3 only when `auto_rdi` is 0. Otherwise it sends `int_bit`.
- R12: `ext_req` is 1 in exactly the cycles where `tx_bit` is taken from `ext_bit`, and `tx_bit` then equals `ext_bit`.
- R13: Each cycle with `frame_start` at 1 advances `mfi_q` by one modulo 4 (00, 01, 10, 11, 00). `mfi_q` holds otherwise.
- R14: Class 9 and the unused codes 10..15 send `int_bit`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode | input | 2 | Framing mode: 0 DS3 C-bit, 1 DS3 M13/M23, 2 E3 G.751, 3 E3 G.832 |
| ctrl_wr | input | 1 | Control register write enable |
| ctrl_wdata | input | 8 | Control register write data |
| ctrl_q | output | 8 | Control register read value |
| auto_rdi | input | 1 | Automatic RDI enabled (E3 modes) |
| mfi_en | input | 1 | Carry the multiframe indicator in the MA byte (G.832) |
| frame_start | input | 1 | One-cycle pulse at each frame start |
| oh_class | input | 4 | Overhead class code of the current bit position |
| int_bit | input | 1 | Internally generated overhead bit |
| ext_bit | input | 1 | External insertion serial bit |
| pay_bit | input | 1 | Payload stream bit |
| pd_bit | input | 1 | Programmable payload-dependent value bit |
| alm_force | input | 1 | Force alarm pattern |
| alm_bit | input | 1 | Alarm pattern bit |
| tx_bit | output | 1 | Selected transmit bit |
| ext_req | output | 1 | Request strobe for the external bit |
| mfi_q | output | 2 | Multiframe indicator value |

## Verification
Every cycle, assertions check four things:
- alarm priority;
- the ext-data override;
- payload pass-through;
- that the strobe only appears while the external bit is on the line.

They also check that the E3 modes never request the parity bit, that the reserved bit stays clear, and that the indicator counter steps once per frame-start pulse. Only the bench's sweeps can show the full per-class, per-mode source choice. These sweeps cover all 128 control settings, the four modes, every class and the auto-RDI, indicator-enable and alarm inputs. The sweeps also show the G.832 trail-trace zero default and the indicator bits being read from the counter.

// File: rtl/tx_oh_pkg.sv
// Shared types and constants for the transmit overhead source selector.
// Assumes the control register layout is fixed by the control bit positions below.
package tx_oh_pkg;

    typedef enum logic [1:0] {
        MODE_DS3_CBIT = 2'd0,
        MODE_DS3_M13  = 2'd1,
        MODE_E3_G751  = 2'd2,
        MODE_E3_G832  = 2'd3
    } frm_mode_e;

    typedef enum logic [3:0] {
        OHC_PAYLOAD = 4'd0,
        OHC_FALIGN  = 4'd1,
        OHC_PARITY  = 4'd2,
        OHC_STUFF   = 4'd3,
        OHC_XARDI   = 4'd4,
        OHC_CPTR    = 4'd5,
        OHC_FEACPD  = 4'd6,
        OHC_MFI_HI  = 4'd7,
        OHC_MFI_LO  = 4'd8,
        OHC_OTHER   = 4'd9
    } oh_class_e;

    typedef enum logic [2:0] {
        SRC_INT,
        SRC_EXT,
        SRC_PAY,
        SRC_PD,
        SRC_ZERO,
        SRC_MFI_HI,
        SRC_MFI_LO
    } bit_src_e;

    localparam int CTRL_W     = 8;
    localparam int CB_XRDI    = 0;
    localparam int CB_PBIT    = 1;
    localparam int CB_FALIGN  = 2;
    localparam int CB_STUFF   = 3;
    localparam int CB_EXTDATA = 4;
    localparam int CB_FEACPD  = 5;
    localparam int CB_CPTR    = 6;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 8'h7F;

endpackage

// File: rtl/txoh_ctrl_reg.sv
// Control register holding the external-insertion enables.
// Assumes synchronous active-low reset; bits outside WMASK always read zero.
module txoh_ctrl_reg #(
    parameter int              W     = 8,
    parameter logic [W-1:0]    WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);
    // Load masked write data; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (wr)
            q <= wdata & WMASK;
    end
endmodule

// File: rtl/txoh_mfi_cnt.sv
// Multiframe indicator counter, one step per frame-start pulse, wrapping.
// Assumes frame_start is a single-cycle pulse from the frame timing logic.
module txoh_mfi_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Advance on each step, natural modulo wrap.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (step)
            cnt <= cnt + ONE;
    end
endmodule

// File: rtl/txoh_src_mux.sv
// Per-bit source decision from mode, control bits and overhead class.
// Purely combinational; assumes the class code is valid in the same cycle.
module txoh_src_mux
    import tx_oh_pkg::*;
(
    input  logic [1:0]        mode,
    input  logic [CTRL_W-1:0] ctrl,
    input  logic [3:0]        oh_class,
    input  logic              auto_rdi,
    input  logic              mfi_en,
    output bit_src_e          src
);
    frm_mode_e md;
    logic      is_ds3;
    logic      is_g832;
    logic      is_cbit;
    logic      stuff_mode;

    // Decode the framing mode into the groups the rules use.
    always_comb begin
        md         = frm_mode_e'(mode);
        is_ds3     = (md == MODE_DS3_CBIT) || (md == MODE_DS3_M13);
        is_g832    = (md == MODE_E3_G832);
        is_cbit    = (md == MODE_DS3_CBIT);
        stuff_mode = (md == MODE_DS3_M13) || (md == MODE_E3_G751);
    end

    // Choose the bit source; ext data overrides all other control bits.
    always_comb begin
        src = SRC_INT;
        if (oh_class == OHC_PAYLOAD) begin
            src = SRC_PAY;
        end else if (ctrl[CB_EXTDATA]) begin
            src = SRC_PAY;
        end else begin
            unique case (oh_class)
                OHC_FALIGN:
                    src = ctrl[CB_FALIGN] ? SRC_EXT : SRC_INT;
                OHC_PARITY:
                    src = (is_ds3 && ctrl[CB_PBIT]) ? SRC_EXT : SRC_INT;
                OHC_STUFF:
                    src = (stuff_mode && ctrl[CB_STUFF]) ? SRC_EXT : SRC_PAY;
                OHC_XARDI:
                    src = (ctrl[CB_XRDI] && (is_ds3 || !auto_rdi)) ? SRC_EXT : SRC_INT;
                OHC_CPTR:
                    if (is_cbit)
                        src = ctrl[CB_CPTR] ? SRC_EXT : SRC_INT;
                    else if (is_g832)
                        src = ctrl[CB_CPTR] ? SRC_EXT : SRC_ZERO;
                    else
                        src = SRC_INT;
                OHC_FEACPD:
                    if (is_cbit)
                        src = ctrl[CB_FEACPD] ? SRC_EXT : SRC_INT;
                    else if (is_g832)
                        src = ctrl[CB_FEACPD] ? SRC_EXT : SRC_PD;
                    else
                        src = SRC_INT;
                OHC_MFI_HI, OHC_MFI_LO:
                    if (!is_g832)
                        src = SRC_INT;
                    else if (ctrl[CB_FEACPD])
                        src = SRC_EXT;
                    else if (!mfi_en)
                        src = SRC_PD;
                    else
                        src = (oh_class == OHC_MFI_HI) ? SRC_MFI_HI : SRC_MFI_LO;
                default:
                    src = SRC_INT;
            endcase
        end
    end
endmodule

// File: rtl/tx_oh_select.sv
// Transmit overhead source selector: picks each transmitted bit from the
// internal, external, payload, programmable or indicator source, with alarm
// forcing on top. Assumes the class code and data bits arrive together.
module tx_oh_select
    import tx_oh_pkg::*;
#(
    parameter int MFI_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic              auto_rdi,
    input  logic              mfi_en,
    input  logic              frame_start,
    input  logic [3:0]        oh_class,
    input  logic              int_bit,
    input  logic              ext_bit,
    input  logic              pay_bit,
    input  logic              pd_bit,
    input  logic              alm_force,
    input  logic              alm_bit,
    output logic              tx_bit,
    output logic              ext_req,
    output logic [MFI_W-1:0]  mfi_q
);
    bit_src_e src;
    logic     sel_bit;

    txoh_ctrl_reg #(.W(CTRL_W), .WMASK(CTRL_WMASK)) u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (ctrl_wr),
        .wdata (ctrl_wdata),
        .q     (ctrl_q)
    );

    txoh_mfi_cnt #(.CNT_W(MFI_W)) u_mfi (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (frame_start),
        .cnt   (mfi_q)
    );

    txoh_src_mux u_mux (
        .mode     (mode),
        .ctrl     (ctrl_q),
        .oh_class (oh_class),
        .auto_rdi (auto_rdi),
        .mfi_en   (mfi_en),
        .src      (src)
    );

    // Map the chosen source to its data bit.
    always_comb begin
        unique case (src)
            SRC_EXT:    sel_bit = ext_bit;
            SRC_PAY:    sel_bit = pay_bit;
            SRC_PD:     sel_bit = pd_bit;
            SRC_ZERO:   sel_bit = 1'b0;
            SRC_MFI_HI: sel_bit = mfi_q[MFI_W-1];
            SRC_MFI_LO: sel_bit = mfi_q[MFI_W-2];
            default:    sel_bit = int_bit;
        endcase
    end

    // Alarm forcing wins over every source and suppresses the request.
    always_comb begin
        tx_bit  = alm_force ? alm_bit : sel_bit;
        ext_req = !alm_force && (src == SRC_EXT);
    end
endmodule

// File: rtl/txoh_checker.sv
// Cycle-level properties of the transmit overhead source selector.
// Bound to tx_oh_select; assumes synchronous active-low reset.
module txoh_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [7:0] ctrl_q,
    input logic       frame_start,
    input logic [3:0] oh_class,
    input logic       ext_bit,
    input logic       pay_bit,
    input logic       alm_force,
    input logic       alm_bit,
    input logic       tx_bit,
    input logic       ext_req,
    input logic [1:0] mfi_q
);
    a_r1_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[7] == 1'b0);

    a_r2_alarm_wins: assert property (@(posedge clk) disable iff (!rst_n)
        alm_force |-> (tx_bit == alm_bit) && !ext_req);

    a_r3_extdata_payload: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_force && ctrl_q[4]) |-> (tx_bit == pay_bit) && !ext_req);

    a_r4_payload_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!alm_force && oh_class == 4'd0) |-> (tx_bit == pay_bit) && !ext_req);

    a_r6_no_e3_parity_req: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && oh_class == 4'd2) |-> !ext_req);

    a_r12_req_carries_ext: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req |-> (tx_bit == ext_bit));

    a_r13_mfi_step: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mfi_q == $past(mfi_q) + 2'd1));

    a_r13_mfi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> $stable(mfi_q));
endmodule

bind tx_oh_select txoh_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode),
    .ctrl_q      (ctrl_q),
    .frame_start (frame_start),
    .oh_class    (oh_class),
    .ext_bit     (ext_bit),
    .pay_bit     (pay_bit),
    .alm_force   (alm_force),
    .alm_bit     (alm_bit),
    .tx_bit      (tx_bit),
    .ext_req     (ext_req),
    .mfi_q       (mfi_q)
);

// File: tb/tx_oh_select_test.sv
// Sweeps every control setting, mode, class and side input of the selector
// and compares against expected values derived from the requirements.
module tx_oh_select_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = '0;
    logic       ctrl_wr = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic [7:0] ctrl_q;
    logic       auto_rdi = 1'b0;
    logic       mfi_en = 1'b0;
    logic       frame_start = 1'b0;
    logic [3:0] oh_class = '0;
    logic       int_bit = 1'b0, ext_bit = 1'b0, pay_bit = 1'b0, pd_bit = 1'b0;
    logic       alm_force = 1'b0, alm_bit = 1'b0;
    logic       tx_bit, ext_req;
    logic [1:0] mfi_q;

    int n_cmp = 0;
    int n_bad = 0;
    int mfi_model = 0;

    always #5 clk = ~clk;

    tx_oh_select uut (
        .clk(clk), .rst_n(rst_n), .mode(mode), .ctrl_wr(ctrl_wr),
        .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .auto_rdi(auto_rdi),
        .mfi_en(mfi_en), .frame_start(frame_start), .oh_class(oh_class),
        .int_bit(int_bit), .ext_bit(ext_bit), .pay_bit(pay_bit), .pd_bit(pd_bit),
        .alm_force(alm_force), .alm_bit(alm_bit), .tx_bit(tx_bit),
        .ext_req(ext_req), .mfi_q(mfi_q)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_cmp++;
        if (act != exp_v) begin
            n_bad++;
            if (n_bad < 30)
                $display("FAIL %s: actual %0d expected %0d (mode %0d ctrl %h class %0d)",
                         req, act, exp_v, mode, ctrl_q, oh_class);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Expected source: 0 int,1 ext,2 pay,3 pd,4 zero,5 mfi hi,6 mfi lo,7 alarm
    task automatic expect_src(input logic [6:0] c, input int md, input int cls,
                              input logic ar, input logic me,
                              output int s, output string req);
        logic ds3, g832;
        ds3  = (md < 2);
        g832 = (md == 3);
        s = 0;
        if (cls == 0)   begin s = 2; req = "R4"; end
        else if (c[4])  begin s = 2; req = "R3"; end
        else begin
            case (cls)
                1: begin req = "R5"; s = c[2] ? 1 : 0; end
                2: begin req = "R6"; s = (ds3 && c[1]) ? 1 : 0; end
                3: begin req = "R7"; s = ((md == 1 || md == 2) && c[3]) ? 1 : 2; end
                4: begin req = "R11"; s = (c[0] && (ds3 || !ar)) ? 1 : 0; end
                5: begin req = "R8";
                     if (md == 0) s = c[6] ? 1 : 0;
                     else if (g832) s = c[6] ? 1 : 4;
                     else s = 0;
                   end
                6: begin req = "R9";
                     if (md == 0) s = c[5] ? 1 : 0;
                     else if (g832) s = c[5] ? 1 : 3;
                     else s = 0;
                   end
                7, 8: begin req = "R10";
                     if (!g832) s = 0;
                     else if (c[5]) s = 1;
                     else if (!me) s = 3;
                     else s = (cls == 7) ? 5 : 6;
                   end
                default: begin req = "R14"; s = 0; end
            endcase
        end
    endtask

    task automatic write_ctrl(input logic [7:0] v);
        @(negedge clk);
        ctrl_wr = 1'b1;
        ctrl_wdata = v;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic pulse_frame();
        @(negedge clk);
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        mfi_model = (mfi_model + 1) % 4;
    endtask

    initial begin
        #1_000_000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset ctrl", int'(ctrl_q), 0);
        check("R1 reset mfi", int'(mfi_q), 0);

        write_ctrl(8'hFF);
        check("R1 reserved bit", int'(ctrl_q), 8'h7F);
        write_ctrl(8'h25);
        check("R1 write value", int'(ctrl_q), 8'h25);

        // R13: step through and past the wrap, with idle gaps.
        for (int k = 0; k < 6; k++) begin
            pulse_frame();
            repeat (k % 3) @(negedge clk);
            check("R13 mfi count", int'(mfi_q), mfi_model);
        end
        // Leave mfi at 2 so the two indicator bits differ.
        while (mfi_model != 2) pulse_frame();
        check("R13 mfi hold", int'(mfi_q), 2);

        for (int c = 0; c < 128; c++) begin
            write_ctrl(8'(c));
            for (int md = 0; md < 4; md++)
            for (int cls = 0; cls < 16; cls++)
            for (int sd = 0; sd < 4; sd++)
            for (int al = 0; al < 2; al++)
            for (int p = 0; p < 4; p++) begin
                int s, eb;
                string req;
                mode = 2'(md);
                oh_class = 4'(cls);
                auto_rdi = sd[0];
                mfi_en = sd[1];
                alm_force = al[0];
                int_bit = p[0];
                ext_bit = ~p[0];
                pay_bit = p[1];
                pd_bit = ~p[1];
                alm_bit = p[0] ^ p[1];
                #1;
                expect_src(7'(c), md, cls, sd[0], sd[1], s, req);
                if (al != 0) begin s = 7; req = "R2"; end
                case (s)
                    0: eb = p[0];
                    1: eb = !p[0];
                    2: eb = p[1];
                    3: eb = !p[1];
                    4: eb = 0;
                    5: eb = 1;
                    6: eb = 0;
                    default: eb = p[0] ^ p[1];
                endcase
                check(req, int'(tx_bit), eb);
                check("R12 ext_req", int'(ext_req), (s == 1) ? 1 : 0);
            end
        end
        alm_force = 1'b0;
        summary();
    end
endmodule